// File: doc/BRIEF.md
# Framed Serial Command Port

This block is the serial front end of a digitally controlled resistor. An external master frames each transfer with an active-low frame line. It clocks data with a serial clock that idles low. It presents one data bit per clock, and the block captures that bit on the falling edge of the serial clock. The three serial pins are asynchronous to the block. They pass through synchronisers into an oversampling system clock domain, and every serial edge is found from the synchronised samples.

The 16-bit shift register has two roles. It collects the incoming word, and its most significant bit is the serial output. As a result, a frame returns the word that the previous frame left behind, which lets several devices be chained. A command decoder can instead stage a readback word, which then replaces the previous word for exactly one frame. When the frame line rises after a nonzero whole number of 16-bit words, the last 16 bits go to the decoder with a one-cycle strobe. A frame of any other length is dropped. While the memory controller reports busy, frames still shift but no strobe is issued. The output is open-drain: the block only ever pulls the pin low or releases it.

Top module: `serial_frame_port`

## Requirements
- R1: The strobed command word equals the last 16 bits received in the frame, with the earliest of those 16 bits at bit 15. Bits 15:14 are spare, 13:10 carry the command and 9:0 carry data, and all of them are passed through unchanged.
- R2: The command strobe lasts exactly one system clock cycle.
- R3: A strobe is issued at the end of a frame only when the number of serial clocks is a nonzero multiple of 16. A 32-clock frame is accepted, and 31-clock or 33-clock frames are discarded.
- R4: A frame that ends before its 16th serial clock gives no strobe.
- R5: The serial output changes on serial clock rising edges. During a frame it presents, MSB first, the 16 bits that were in the shift register when the frame began.
- R6: In a frame longer than 16 clocks, the output after the first 16 bits repeats the input bits of the same frame, delayed by 16 clocks, so that a second chained device receives them.
- R7: A readback word staged between frames is shifted out, MSB first, in place of the previous word during the next frame only.
- R8: The output pulls low only for a 0 bit while a frame is active. It is released between frames.
- R9: While the high-impedance control is asserted, the output is never pulled low.
- R10: While busy is asserted at the end of a frame, no strobe is issued, but the received bits still enter the shift register.
- R11: After reset, the strobe is low, the output is released, and the shift register holds all zeros.
- R12: Serial clock edges while the frame line is high do not shift the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n_i | input | 1 | Active-low frame line, asynchronous |
| sclk_i | input | 1 | Serial clock, idles low, asynchronous |
| sdi_i | input | 1 | Serial data in, asynchronous |
| busy_i | input | 1 | Memory controller busy; suppresses the strobe |
| rb_load_i | input | 1 | Stage rb_word_i for the next frame |
| rb_word_i | input | 16 | Readback word to shift out |
| sdo_hiz_i | input | 1 | Force the serial output released |
| sdo_pull_low_o | output | 1 | Open-drain enable: 1 pulls the output pin low |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_word_o | output | 16 | Received command word, valid with the strobe |

## Verification
Each pin change takes two synchroniser cycles to be seen and one more cycle to register its effect. The bench therefore changes pins on falling system clock edges and counts the cycles to each result. It samples the strobe and word on the third falling system edge after the frame line rises, and it requires the strobe to be low again one cycle later. The output enable has one more register, so it is sampled five system cycles after each serial clock rise. This is just before the master's falling edge, and the output has settled by then. After a frame, the released output is checked three cycles after the strobe sample.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  typedef struct packed {
    logic frame_start;
    logic frame_end;
    logic shift_in;
    logic shift_out;
  } sfp_evt_t;
endpackage

// File: rtl/sfp_sync_edge.sv
module sfp_sync_edge
  import sfp_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     frame_n_pin,
  input  logic     sclk_pin,
  input  logic     sdi_pin,
  output sfp_evt_t evt,
  output logic     sdi_s,
  output logic     frame_n_s
);
  localparam logic [2:0] IDLE_VEC = 3'b100;

  logic [2:0] pin_vec;
  logic [2:0] stg_q [STAGES];
  logic [2:0] prev_q;
  logic [2:0] cur;

  assign pin_vec = {frame_n_pin, sclk_pin, sdi_pin};

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= IDLE_VEC;
        else        stg_q[g] <= pin_vec;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= IDLE_VEC;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign cur = stg_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_VEC;
    else        prev_q <= cur;
  end

  always_comb begin
    evt.frame_start = prev_q[2] & ~cur[2];
    evt.frame_end   = ~prev_q[2] & cur[2];
    evt.shift_in    = prev_q[1] & ~cur[1] & ~cur[2];
    evt.shift_out   = ~prev_q[1] & cur[1] & ~cur[2];
  end

  assign sdi_s     = cur[0];
  assign frame_n_s = cur[2];

  // R12: no serial edge is reported while the synchronised frame line is high
  a_r12_no_edge_idle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n_s |-> !(evt.shift_in || evt.shift_out));
endmodule

// File: rtl/sfp_bit_counter.sv
module sfp_bit_counter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic frame_ok
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             seen_q, seen_d;

  always_comb begin
    cnt_d  = cnt_q;
    seen_d = seen_q;
    if (clr) begin
      cnt_d  = '0;
      seen_d = 1'b0;
    end else if (step) begin
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        seen_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
    end
  end

  assign frame_ok = seen_q & (cnt_q == '0);

  // R3: the counter only moves on a serial falling edge or a frame start
  a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !step) |=> $stable(cnt_q));
  // R4: a fresh frame never qualifies before a whole word is counted
  a_r4_clear_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !frame_ok);
endmodule

// File: rtl/sfp_shift_core.sv
module sfp_shift_core
  import sfp_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sfp_evt_t          evt,
  input  logic              sdi_s,
  input  logic              rb_load,
  input  logic [WORD_W-1:0] rb_word,
  input  logic              hiz,
  output logic [WORD_W-1:0] word,
  output logic              pull_low
);
  logic [WORD_W-1:0] sreg_q, sreg_d;
  logic [WORD_W-1:0] rb_q, rb_d;
  logic              staged_q, staged_d;
  logic              act_q, act_d;
  logic              bit_q, bit_d;
  logic              pull_q, pull_d;
  logic [WORD_W-1:0] start_word;

  assign start_word = staged_q ? rb_q : sreg_q;

  always_comb begin
    sreg_d   = sreg_q;
    rb_d     = rb_q;
    staged_d = staged_q;
    act_d    = act_q;
    bit_d    = bit_q;
    if (evt.frame_start) begin
      sreg_d   = start_word;
      staged_d = 1'b0;
      act_d    = 1'b1;
      bit_d    = start_word[WORD_W-1];
    end else begin
      if (evt.shift_in)  sreg_d = {sreg_q[WORD_W-2:0], sdi_s};
      if (evt.shift_out) bit_d  = sreg_q[WORD_W-1];
      if (evt.frame_end) act_d  = 1'b0;
    end
    if (rb_load) begin
      rb_d     = rb_word;
      staged_d = 1'b1;
    end
    pull_d = act_q & ~hiz & ~bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q   <= '0;
      rb_q     <= '0;
      staged_q <= 1'b0;
      act_q    <= 1'b0;
      bit_q    <= 1'b1;
      pull_q   <= 1'b0;
    end else begin
      sreg_q   <= sreg_d;
      rb_q     <= rb_d;
      staged_q <= staged_d;
      act_q    <= act_d;
      bit_q    <= bit_d;
      pull_q   <= pull_d;
    end
  end

  assign word     = sreg_q;
  assign pull_low = pull_q;

  // R12: register content only moves on a serial falling edge or a frame start
  a_r12_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt.shift_in && !evt.frame_start) |=> $stable(sreg_q));
  // R9: high-impedance request releases the output on the next cycle
  a_r9_hiz_release: assert property (@(posedge clk) disable iff (!rst_n)
    hiz |=> !pull_q);
  // R8: outside a frame the output is released
  a_r8_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |=> !pull_q);
  // R7: a staged word is consumed by the next frame start
  a_r7_stage_used: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.frame_start && !rb_load) |=> !staged_q);
endmodule

// File: rtl/serial_frame_port.sv
module serial_frame_port
  import sfp_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              busy_i,
  input  logic              rb_load_i,
  input  logic [WORD_W-1:0] rb_word_i,
  input  logic              sdo_hiz_i,
  output logic              sdo_pull_low_o,
  output logic              cmd_valid_o,
  output logic [WORD_W-1:0] cmd_word_o
);
  sfp_evt_t          evt;
  logic              sdi_s;
  logic              frame_n_s;
  logic              frame_ok;
  logic [WORD_W-1:0] shreg;
  logic              valid_q, valid_d;
  logic [WORD_W-1:0] word_q, word_d;

  sfp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .frame_n_pin(frame_n_i), .sclk_pin(sclk_i), .sdi_pin(sdi_i),
    .evt(evt), .sdi_s(sdi_s), .frame_n_s(frame_n_s)
  );

  sfp_bit_counter #(.WORD_W(WORD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .clr(evt.frame_start), .step(evt.shift_in),
    .frame_ok(frame_ok)
  );

  sfp_shift_core #(.WORD_W(WORD_W)) u_core (
    .clk(clk), .rst_n(rst_n), .evt(evt), .sdi_s(sdi_s),
    .rb_load(rb_load_i), .rb_word(rb_word_i), .hiz(sdo_hiz_i),
    .word(shreg), .pull_low(sdo_pull_low_o)
  );

  always_comb begin
    valid_d = evt.frame_end & frame_ok & ~busy_i;
    word_d  = valid_d ? shreg : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= valid_d;
      word_q  <= word_d;
    end
  end

  assign cmd_valid_o = valid_q;
  assign cmd_word_o  = word_q;

  // R2: the strobe is a single-cycle pulse
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);
  // R10: busy blocks the strobe
  a_r10_busy_block: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> !cmd_valid_o);
  // R3: a strobe follows only a whole-word count
  a_r3_whole_words: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> $past(frame_ok));
  // R1: a strobe is issued only once the frame line is back high
  a_r1_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> frame_n_s);
endmodule

// File: tb/sim_serial_frame_port.sv
module sim_serial_frame_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_n, sclk, sdi, busy, rb_load, hiz;
  logic [15:0] rb_word;
  logic        pull_low, cmd_valid;
  logic [15:0] cmd_word;

  int          n_tests = 0;
  int          n_fail  = 0;
  logic [15:0] mdl = 16'h0000;
  logic        staged = 1'b0;
  logic [15:0] rbv = 16'h0000;
  bit          idle_toggled = 1'b0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  serial_frame_port u0 (
    .clk(clk), .rst_n(rst_n), .frame_n_i(frame_n), .sclk_i(sclk), .sdi_i(sdi),
    .busy_i(busy), .rb_load_i(rb_load), .rb_word_i(rb_word), .sdo_hiz_i(hiz),
    .sdo_pull_low_o(pull_low), .cmd_valid_o(cmd_valid), .cmd_word_o(cmd_word)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic bit exp_strobe(input int n, input logic bz);
    return (n > 0) && (n % 16 == 0) && !bz;
  endfunction

  task automatic stage_rb(input logic [15:0] v);
    rb_word = v; rb_load = 1'b1;
    wait_clk(1);
    rb_load = 1'b0;
    staged = 1'b1; rbv = v;
  endtask

  task automatic run_frame(input int n, input logic [63:0] bits);
    bit          used_rb;
    logic        b;
    logic [15:0] exp_pull;
    bit          ev;
    used_rb = staged;
    if (staged) begin mdl = rbv; staged = 1'b0; end
    frame_n = 1'b0;
    wait_clk(5);
    for (int i = 0; i < n; i++) begin
      b = bits[n-1-i];
      sclk = 1'b1; sdi = b;
      wait_clk(5);
      exp_pull = {15'd0, (!hiz && !mdl[15])};
      if (hiz)                   chk("R9",  {15'd0, pull_low}, exp_pull);
      else if (i >= 16)          chk("R6",  {15'd0, pull_low}, exp_pull);
      else if (used_rb)          chk("R7",  {15'd0, pull_low}, exp_pull);
      else if (idle_toggled)     chk("R12", {15'd0, pull_low}, exp_pull);
      else                       chk("R5",  {15'd0, pull_low}, exp_pull);
      sclk = 1'b0;
      wait_clk(5);
      mdl = {mdl[14:0], b};
    end
    idle_toggled = 1'b0;
    frame_n = 1'b1;
    wait_clk(3);
    ev = exp_strobe(n, busy);
    if (busy)        chk("R10", {15'd0, cmd_valid}, {15'd0, ev});
    else if (n < 16) chk("R4",  {15'd0, cmd_valid}, {15'd0, ev});
    else             chk("R3",  {15'd0, cmd_valid}, {15'd0, ev});
    if (ev) chk("R1", cmd_word, mdl);
    wait_clk(1);
    chk("R2", {15'd0, cmd_valid}, 16'h0);
    wait_clk(2);
    chk("R8", {15'd0, pull_low}, 16'h0);
  endtask

  task automatic idle_sclk(input int k);
    for (int i = 0; i < k; i++) begin
      sdi = i[0]; sclk = 1'b1; wait_clk(4);
      sclk = 1'b0; wait_clk(4);
    end
    idle_toggled = 1'b1;
  endtask

  initial begin
    wait_clk(199000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int lens [8] = '{16, 32, 48, 15, 17, 31, 33, 5};
    void'($urandom(32'd2024));
    rst_n = 1'b0; frame_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    busy = 1'b0; rb_load = 1'b0; hiz = 1'b0; rb_word = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    // R11: reset state
    chk("R11", {15'd0, cmd_valid}, 16'h0);
    chk("R11", {15'd0, pull_low}, 16'h0);
    chk("R11", cmd_word, 16'h0);
    // first frame returns the all-zero reset content (R11 via SDO samples)
    run_frame(16, 64'h1C03);
    run_frame(16, 64'h0500);
    // two chained words: R6 and R3
    run_frame(32, 64'hA5C3_3C5A);
    // length corners: R3, R4
    run_frame(31, 64'h7FFF_FFFF);
    run_frame(33, 64'h1_2345_6789);
    run_frame(15, 64'h5555);
    run_frame(0, 64'h0);
    // staged readback, used once: R7
    stage_rb(16'h8421);
    run_frame(16, 64'h0F0F);
    run_frame(16, 64'hF0F0);
    // idle serial clocks ignored: R12
    idle_sclk(5);
    run_frame(16, 64'h1234);
    // high-impedance: R9
    hiz = 1'b1;
    run_frame(16, 64'h0000);
    hiz = 1'b0;
    // busy suppresses the strobe but bits still enter: R10
    busy = 1'b1;
    run_frame(16, 64'hBEEF);
    busy = 1'b0;
    run_frame(16, 64'h3001);
    // constrained random frames
    for (int k = 0; k < 40; k++) begin
      if ($urandom % 5 == 0) stage_rb(16'($urandom));
      if ($urandom % 7 == 0) idle_sclk(2);
      busy = ($urandom % 6 == 0);
      hiz  = ($urandom % 8 == 0);
      run_frame(lens[$urandom % 8], {$urandom, $urandom});
      busy = 1'b0; hiz = 1'b0;
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule